// File: doc/BRIEF.md
# Read Beat Delay Injector

This block sits between a read-only bus master and its slave, on the read address and read data channels of an AXI4 link. It adds a fixed wait in front of every read data beat, the first beat of a burst included, so each beat arrives late at the master. Such a block is useful for exercising a master's tolerance of slow memory, or for opening a window in which each beat can be observed before it is consumed.

The address and data payloads pass straight through. Only the valid and ready wires are gated. While a burst is in flight the block shuts the address channel, so at most one read is outstanding. Every beat must then wait out a programmable gap, GAP cycles with a default of 15. A 4-bit down-counter times this gap. It is loaded when the slave first presents the opening beat, and again after each handshake that is not the last of the burst. While the wait runs, RVALID toward the master and RREADY toward the slave are both held low. A released beat is transferred only in a cycle where the master accepts it, and the slave sees its ready in that same cycle.

Top module: `axi_read_gap_injector`

## Requirements
- R1: After reset the block is idle. m_arready_o equals s_arready_i, s_arvalid_o equals m_arvalid_i, and m_rvalid_o is low.
- R2: The slave may first present the opening beat of a burst in cycle c. The master then sees m_rvalid_o no earlier than cycle c+GAP+1, which is c+16 at the default. With the master always ready, the beat transfers in exactly that cycle. m_rvalid_o and s_rready_o stay low until then.
- R3: For each later beat, let n be the cycle of the previous handshake and L the number of cycles the slave waits after that handshake before presenting the beat. m_rvalid_o rises no earlier than cycle max(n+GAP+1, n+1+L). With the master always ready, the beat transfers in exactly that cycle.
- R4: After an address handshake, m_arready_o and s_arvalid_o stay low until the cycle after the handshake of the beat with RLAST=1. In that cycle m_arready_o again equals s_arready_i.
- R5: s_rready_o is high together with s_rvalid_i only in cycles where m_rvalid_o and m_rready_i are both high. The slave and master handshakes always coincide.
- R6: m_rdata_o, m_rresp_o, m_rid_o and m_rlast_o equal the slave's values in every cycle. The address payloads (address, ID, length, size, burst type) reach the slave unchanged.
- R7: Bursts of 1 to 64 beats (ARLEN 0 to 63) of 64-bit data are delivered in full: ARLEN+1 handshakes, with RLAST high only on the last one.
- R8: A released beat that the master does not accept stays valid toward the master, with no new wait, until it is accepted. A throttled master therefore adds only its own stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_arvalid_i | input | 1 | Address valid from master |
| m_arready_o | output | 1 | Address ready to master, low while a read is in flight |
| m_araddr_i | input | ADDR_W | Read address from master |
| m_arid_i | input | ID_W | Read ID from master |
| m_arlen_i | input | 8 | Burst length minus one from master |
| m_arsize_i | input | 3 | Beat size code from master |
| m_arburst_i | input | 2 | Burst type from master |
| s_arvalid_o | output | 1 | Address valid to slave |
| s_arready_i | input | 1 | Address ready from slave |
| s_araddr_o | output | ADDR_W | Read address to slave |
| s_arid_o | output | ID_W | Read ID to slave |
| s_arlen_o | output | 8 | Burst length minus one to slave |
| s_arsize_o | output | 3 | Beat size code to slave |
| s_arburst_o | output | 2 | Burst type to slave |
| s_rvalid_i | input | 1 | Data valid from slave |
| s_rready_o | output | 1 | Data ready to slave, low during a wait |
| s_rdata_i | input | DATA_W | Read data from slave |
| s_rresp_i | input | 2 | Response code from slave |
| s_rid_i | input | ID_W | Response ID from slave |
| s_rlast_i | input | 1 | Last beat marker from slave |
| m_rvalid_o | output | 1 | Data valid to master, low during a wait |
| m_rready_i | input | 1 | Data ready from master |
| m_rdata_o | output | DATA_W | Read data to master |
| m_rresp_o | output | 2 | Response code to master |
| m_rid_o | output | ID_W | Response ID to master |
| m_rlast_o | output | 1 | Last beat marker to master |

## Verification
A gap counter that reloads late, misses a reload or sticks shows up at the first beat it touches. The master handshake then lands a cycle or more away from the cycle the bench predicts, or a beat is released before its wait is over. A first-beat flag that never clears hides RVALID for the rest of the burst, and the watchdog catches it. One that never sets lets the opening beat through 16 cycles early. A busy flag that clears too early or too late is seen on the address channel within one cycle of the last beat: m_arready_o is high during the burst, or low after it. Mismatched slave and master handshakes would drop or repeat a beat, and the per-cycle comparison of the two sides catches this in the cycle it happens.

// File: rtl/rgap_pkg.sv
package rgap_pkg;
  // Transaction phase: idle, waiting for the first beat to appear, burst in progress
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FIRST = 2'd1,
    RD_BURST = 2'd2
  } rd_phase_e;

  localparam int unsigned AXI_LEN_W   = 8;
  localparam int unsigned AXI_SIZE_W  = 3;
  localparam int unsigned AXI_BURST_W = 2;
  localparam int unsigned AXI_RESP_W  = 2;
endpackage

// File: rtl/rgap_txn_tracker.sv
module rgap_txn_tracker
  import rgap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ar_hs_i,
  input  logic first_start_i,
  input  logic last_hs_i,
  output logic busy_o,
  output logic first_pend_o
);
  rd_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      RD_IDLE:  if (ar_hs_i)       phase_d = RD_FIRST;
      RD_FIRST: if (first_start_i) phase_d = RD_BURST;
      RD_BURST: if (last_hs_i)     phase_d = RD_IDLE;
      default:                     phase_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= RD_IDLE;
    else         phase_q <= phase_d;
  end

  assign busy_o       = (phase_q != RD_IDLE);
  assign first_pend_o = (phase_q == RD_FIRST);
endmodule

// File: rtl/rgap_gap_timer.sv
module rgap_gap_timer #(
  parameter int unsigned GAP = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = (GAP < 1) ? 1 : $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/rgap_ar_gate.sv
module rgap_ar_gate
  import rgap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 4
) (
  input  logic                   block_i,
  input  logic                   m_arvalid_i,
  output logic                   m_arready_o,
  input  logic [ADDR_W-1:0]      m_araddr_i,
  input  logic [ID_W-1:0]        m_arid_i,
  input  logic [AXI_LEN_W-1:0]   m_arlen_i,
  input  logic [AXI_SIZE_W-1:0]  m_arsize_i,
  input  logic [AXI_BURST_W-1:0] m_arburst_i,
  output logic                   s_arvalid_o,
  input  logic                   s_arready_i,
  output logic [ADDR_W-1:0]      s_araddr_o,
  output logic [ID_W-1:0]        s_arid_o,
  output logic [AXI_LEN_W-1:0]   s_arlen_o,
  output logic [AXI_SIZE_W-1:0]  s_arsize_o,
  output logic [AXI_BURST_W-1:0] s_arburst_o,
  output logic                   ar_hs_o
);
  assign s_arvalid_o = m_arvalid_i & ~block_i;
  assign m_arready_o = s_arready_i & ~block_i;
  assign s_araddr_o  = m_araddr_i;
  assign s_arid_o    = m_arid_i;
  assign s_arlen_o   = m_arlen_i;
  assign s_arsize_o  = m_arsize_i;
  assign s_arburst_o = m_arburst_i;
  assign ar_hs_o     = m_arvalid_i & m_arready_o;
endmodule

// File: rtl/rgap_r_gate.sv
module rgap_r_gate
  import rgap_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ID_W   = 4
) (
  input  logic                  hold_i,
  input  logic                  s_rvalid_i,
  output logic                  s_rready_o,
  input  logic [DATA_W-1:0]     s_rdata_i,
  input  logic [AXI_RESP_W-1:0] s_rresp_i,
  input  logic [ID_W-1:0]       s_rid_i,
  input  logic                  s_rlast_i,
  output logic                  m_rvalid_o,
  input  logic                  m_rready_i,
  output logic [DATA_W-1:0]     m_rdata_o,
  output logic [AXI_RESP_W-1:0] m_rresp_o,
  output logic [ID_W-1:0]       m_rid_o,
  output logic                  m_rlast_o,
  output logic                  beat_hs_o
);
  assign m_rvalid_o = s_rvalid_i & ~hold_i;
  // slave only sees ready in the cycle the master accepts
  assign s_rready_o = m_rready_i & ~hold_i;
  assign m_rdata_o  = s_rdata_i;
  assign m_rresp_o  = s_rresp_i;
  assign m_rid_o    = s_rid_i;
  assign m_rlast_o  = s_rlast_i;
  assign beat_hs_o  = m_rvalid_o & m_rready_i;
endmodule

// File: rtl/axi_read_gap_injector.sv
module axi_read_gap_injector
  import rgap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned GAP    = 15
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   m_arvalid_i,
  output logic                   m_arready_o,
  input  logic [ADDR_W-1:0]      m_araddr_i,
  input  logic [ID_W-1:0]        m_arid_i,
  input  logic [AXI_LEN_W-1:0]   m_arlen_i,
  input  logic [AXI_SIZE_W-1:0]  m_arsize_i,
  input  logic [AXI_BURST_W-1:0] m_arburst_i,
  output logic                   s_arvalid_o,
  input  logic                   s_arready_i,
  output logic [ADDR_W-1:0]      s_araddr_o,
  output logic [ID_W-1:0]        s_arid_o,
  output logic [AXI_LEN_W-1:0]   s_arlen_o,
  output logic [AXI_SIZE_W-1:0]  s_arsize_o,
  output logic [AXI_BURST_W-1:0] s_arburst_o,
  input  logic                   s_rvalid_i,
  output logic                   s_rready_o,
  input  logic [DATA_W-1:0]      s_rdata_i,
  input  logic [AXI_RESP_W-1:0]  s_rresp_i,
  input  logic [ID_W-1:0]        s_rid_i,
  input  logic                   s_rlast_i,
  output logic                   m_rvalid_o,
  input  logic                   m_rready_i,
  output logic [DATA_W-1:0]      m_rdata_o,
  output logic [AXI_RESP_W-1:0]  m_rresp_o,
  output logic [ID_W-1:0]        m_rid_o,
  output logic                   m_rlast_o
);
  logic busy, first_pend, cnt_hold, hold;
  logic ar_hs, beat_hs, first_start, last_hs, load;

  // opening beat waits until the slave actually presents it
  assign first_start = first_pend & s_rvalid_i & ~cnt_hold;
  assign last_hs     = beat_hs & s_rlast_i;
  assign load        = first_start | (beat_hs & ~s_rlast_i);
  assign hold        = cnt_hold | first_pend;

  rgap_txn_tracker u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ar_hs_i      (ar_hs),
    .first_start_i(first_start),
    .last_hs_i    (last_hs),
    .busy_o       (busy),
    .first_pend_o (first_pend)
  );

  rgap_gap_timer #(.GAP(GAP)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .hold_o(cnt_hold)
  );

  rgap_ar_gate #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_ar (
    .block_i    (busy),
    .m_arvalid_i(m_arvalid_i),
    .m_arready_o(m_arready_o),
    .m_araddr_i (m_araddr_i),
    .m_arid_i   (m_arid_i),
    .m_arlen_i  (m_arlen_i),
    .m_arsize_i (m_arsize_i),
    .m_arburst_i(m_arburst_i),
    .s_arvalid_o(s_arvalid_o),
    .s_arready_i(s_arready_i),
    .s_araddr_o (s_araddr_o),
    .s_arid_o   (s_arid_o),
    .s_arlen_o  (s_arlen_o),
    .s_arsize_o (s_arsize_o),
    .s_arburst_o(s_arburst_o),
    .ar_hs_o    (ar_hs)
  );

  rgap_r_gate #(.DATA_W(DATA_W), .ID_W(ID_W)) u_r (
    .hold_i    (hold),
    .s_rvalid_i(s_rvalid_i),
    .s_rready_o(s_rready_o),
    .s_rdata_i (s_rdata_i),
    .s_rresp_i (s_rresp_i),
    .s_rid_i   (s_rid_i),
    .s_rlast_i (s_rlast_i),
    .m_rvalid_o(m_rvalid_o),
    .m_rready_i(m_rready_i),
    .m_rdata_o (m_rdata_o),
    .m_rresp_o (m_rresp_o),
    .m_rid_o   (m_rid_o),
    .m_rlast_o (m_rlast_o),
    .beat_hs_o (beat_hs)
  );
endmodule

// File: rtl/rgap_checker.sv
module rgap_checker #(
  parameter int unsigned GAP = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic m_arvalid_i,
  input logic m_arready_o,
  input logic s_arvalid_o,
  input logic s_rvalid_i,
  input logic s_rready_o,
  input logic s_rlast_i,
  input logic m_rvalid_o,
  input logic m_rready_i
);
  localparam int unsigned GW = $clog2(GAP + 2);

  logic          pend_q;
  logic [GW-1:0] since_q;
  logic          ar_hs, r_hs;

  assign ar_hs = m_arvalid_i & m_arready_o;
  assign r_hs  = m_rvalid_o & m_rready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      since_q <= '0;
    end else begin
      if (ar_hs)                  pend_q <= 1'b1;
      else if (r_hs && s_rlast_i) pend_q <= 1'b0;
      if (ar_hs || r_hs)          since_q <= '0;
      else if (since_q < GW'(GAP)) since_q <= since_q + 1'b1;
    end
  end

  AST_AR_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (!m_arready_o && !s_arvalid_o)); // R4

  AST_BEAT_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rvalid_o |-> (since_q >= GW'(GAP))); // R3

  AST_HOLD_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_hs && !s_rlast_i) |=> (!m_rvalid_o && !s_rready_o)); // R2

  AST_HS_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_rvalid_i && s_rready_o) |-> (m_rvalid_o && m_rready_i)); // R5

  AST_RELEASED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rvalid_o && !m_rready_i) |=> (m_rvalid_o || !s_rvalid_i)); // R8
endmodule

bind axi_read_gap_injector rgap_checker #(.GAP(GAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .m_arvalid_i(m_arvalid_i),
  .m_arready_o(m_arready_o),
  .s_arvalid_o(s_arvalid_o),
  .s_rvalid_i (s_rvalid_i),
  .s_rready_o (s_rready_o),
  .s_rlast_i  (s_rlast_i),
  .m_rvalid_o (m_rvalid_o),
  .m_rready_i (m_rready_i)
);

// File: tb/axi_read_gap_injector_test.sv
module axi_read_gap_injector_test;
  localparam int GAP = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_arvalid_i = 1'b0;
  logic        m_arready_o;
  logic [31:0] m_araddr_i = '0;
  logic [3:0]  m_arid_i = '0;
  logic [7:0]  m_arlen_i = '0;
  logic [2:0]  m_arsize_i = 3'd3;
  logic [1:0]  m_arburst_i = 2'd1;
  logic        s_arvalid_o;
  logic        s_arready_i = 1'b1;
  logic [31:0] s_araddr_o;
  logic [3:0]  s_arid_o;
  logic [7:0]  s_arlen_o;
  logic [2:0]  s_arsize_o;
  logic [1:0]  s_arburst_o;
  logic        s_rvalid_i = 1'b0;
  logic        s_rready_o;
  logic [63:0] s_rdata_i = '0;
  logic [1:0]  s_rresp_i = '0;
  logic [3:0]  s_rid_i = '0;
  logic        s_rlast_i = 1'b0;
  logic        m_rvalid_o;
  logic        m_rready_i = 1'b0;
  logic [63:0] m_rdata_o;
  logic [1:0]  m_rresp_o;
  logic [3:0]  m_rid_o;
  logic        m_rlast_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  axi_read_gap_injector uut (.*);

  function automatic logic [63:0] beat_data(input logic [31:0] a, input int k);
    return {a, 32'(k) ^ 32'hA5A5_0000};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [31:0] addr, input int len, input int lf,
                           input int lb, input bit throttle, input bit probe);
    int dly, idx, prev, expc, bad_early, bad_pay, bad_co, bad_ar;
    bit done;
    @(negedge clk_i);
    m_arvalid_i = 1'b1; m_araddr_i = addr; m_arlen_i = 8'(len);
    m_arid_i = 4'(len); m_arsize_i = 3'd3; m_arburst_i = 2'(len % 3);
    s_rvalid_i = 1'b0; m_rready_i = 1'b0;
    #1;
    chk(m_arready_o == 1'b1 && s_arvalid_o == 1'b1, "R4", "ar accepted when idle", m_arready_o, 1);
    chk(s_araddr_o == addr && s_arlen_o == 8'(len) && s_arid_o == 4'(len)
        && s_arsize_o == 3'd3 && s_arburst_o == 2'(len % 3), "R6", "ar payload", s_araddr_o, addr);
    expc = cyc + 17 + lf; // R2: first slave valid at a+1+lf, release GAP+1 later
    dly = lf; idx = 0; done = 0; prev = 0;
    bad_early = 0; bad_pay = 0; bad_co = 0; bad_ar = 0;
    while (!done) begin
      @(negedge clk_i);
      m_arvalid_i = probe; m_araddr_i = addr ^ 32'h0F0F_0000;
      s_rvalid_i  = (dly == 0);
      s_rdata_i   = beat_data(addr, idx);
      s_rresp_i   = 2'(idx);
      s_rid_i     = 4'(len);
      s_rlast_i   = (idx == len);
      m_rready_i  = throttle ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (probe && (m_arready_o || s_arvalid_o)) bad_ar++;
      if ((m_rvalid_o && m_rready_i) != (s_rvalid_i && s_rready_o)) bad_co++;
      if (m_rvalid_o && cyc < expc) bad_early++;
      if (m_rdata_o != s_rdata_i || m_rresp_o != s_rresp_i || m_rid_o != s_rid_i
          || m_rlast_o != s_rlast_i) bad_pay++;
      if (m_rvalid_o && m_rready_i) begin
        if (throttle)
          chk(cyc >= expc && cyc <= expc + 2, idx == 0 ? "R2" : "R8",
              "throttled beat cycle", cyc, expc);
        else
          chk(cyc == expc, idx == 0 ? "R2" : "R3", "beat handshake cycle", cyc, expc);
        chk(m_rdata_o == beat_data(addr, idx) && m_rlast_o == (idx == len), "R7",
            "beat data/last", m_rdata_o, beat_data(addr, idx));
        prev = cyc;
        idx++;
        dly = lb;
        expc = (prev + GAP + 1 > prev + 1 + lb) ? prev + GAP + 1 : prev + 1 + lb; // R3
        if (idx > len) done = 1;
      end else if (!s_rvalid_i) begin
        dly--;
      end
    end
    chk(idx == len + 1, "R7", "beat count", idx, len + 1);
    chk(bad_early == 0, "R2", "valid shown during wait", bad_early, 0);
    chk(bad_co == 0, "R5", "handshake mismatch cycles", bad_co, 0);
    chk(bad_pay == 0, "R6", "r payload mismatch cycles", bad_pay, 0);
    if (probe) chk(bad_ar == 0, "R4", "ar open during burst", bad_ar, 0);
    @(negedge clk_i);
    m_arvalid_i = 1'b0; s_rvalid_i = 1'b0; s_rlast_i = 1'b0;
    #1;
    chk(m_arready_o == 1'b1 && m_rvalid_o == 1'b0, "R4", "ar reopened after last", m_arready_o, 1);
  endtask

  task automatic run_all();
    int lens[5] = '{0, 1, 2, 3, 63};
    int lfs[3]  = '{0, 2, 19};
    int lbs[3]  = '{0, 7, 20};
    @(negedge clk_i);
    #1;
    chk(m_rvalid_o == 1'b0 && m_arready_o == s_arready_i, "R1", "reset idle", m_arready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    m_arvalid_i = 1'b1; s_arready_i = 1'b0;
    #1;
    chk(m_arready_o == 1'b0 && s_arvalid_o == 1'b1, "R1", "ar ready follows slave", s_arvalid_o, 1);
    m_arvalid_i = 1'b0; s_arready_i = 1'b1;
    for (int t = 0; t < 2; t++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int l = 0; l < 5; l++)
            run_burst(32'h1000_0000 + 32'(l * 256 + a * 16 + b), lens[l], lfs[a], lbs[b],
                      t[0], (l % 2) == 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk_i);
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule